// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block keeps a short run of upcoming instruction bytes ready for an execution unit. It computes a 20-bit physical fetch address from a 16-bit code segment value and a 16-bit fetch offset. The physical address is the segment shifted left by four bits plus the offset. It reads 16-bit words over a simple request/response memory port and places the returned bytes into a six-entry byte queue.

The consumer sees the oldest queued byte together with a valid flag, and can remove one byte per cycle. Fetching continues while the consumer drains the queue, so memory latency overlaps with consumption. A redirect pulse with a new offset empties the queue, discards any word still in flight and restarts fetching at the new offset.

Top module: `ibq_prefetcher`

## Requirements
- R1: While `rst_n` is low, `q_valid` and `mem_req` are low. After reset the fetch offset is zero, so the first request addresses the segment base.
- R2: `mem_addr` is the word-aligned physical address: bits [19:1] of ({code_seg, 4'b0} + fetch offset) truncated to 20 bits, with bit 0 forced to 0. The memory returns the byte at that even address in `mem_rdata[7:0]` and the following odd byte in `mem_rdata[15:8]`.
- R3: A request is raised only when no fetch is outstanding and at least 2 queue slots are free, where a fetch in flight counts as 2 slots used. `mem_req` is never high on two consecutive cycles.
- R4: A fetch from an even offset enqueues the low byte and then the high byte, and advances the fetch offset by 2.
- R5: A fetch from an odd offset enqueues only the high byte of the returned word, and advances the fetch offset by 1.
- R6: `q_byte` is the oldest queued byte. A cycle with `q_pop` high and `q_valid` high removes exactly one byte, including cycles in which a response is being enqueued at the same time.
- R7: With the queue empty, `q_valid` is low and `q_pop` has no effect: the first byte that arrives later is still the byte at the current fetch offset.
- R8: A cycle with `flush` high empties the queue (`q_valid` is low in the next cycle), loads `flush_ofs` as the fetch offset, and raises no request.
- R9: A response to a fetch that was outstanding when `flush` was applied is dropped and never reaches the queue.
- R10: The fetch offset wraps modulo 64 KB inside the segment, so the byte after offset 0xFFFF is at offset 0x0000.
- R11: The queue never holds more than 6 bytes. With no pops, it settles at 6 bytes after an even start and at 5 bytes after an odd start, after exactly 3 requests in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| code_seg | input | 16 | Code segment value used to form fetch addresses |
| flush | input | 1 | Redirect pulse: empty the queue and restart fetching |
| flush_ofs | input | 16 | New fetch offset, loaded when `flush` is high |
| mem_req | output | 1 | One-cycle word fetch request |
| mem_addr | output | 20 | Word-aligned physical fetch address |
| mem_rvalid | input | 1 | Response strobe for the outstanding fetch |
| mem_rdata | input | 16 | Returned word: even byte low, odd byte high |
| q_valid | output | 1 | Queue holds at least one byte |
| q_byte | output | 8 | Oldest queued byte |
| q_pop | input | 1 | Remove the oldest byte this cycle |

## Verification
The byte stream is compared, byte by byte, against the contents of memory starting at the redirect offset. The stream is tried with:
- a full-rate consumer and one-cycle memory latency, which exposes the even-fetch byte order;
- random pops with longer latency, which mixes enqueues and dequeues in the same cycle;
- odd start offsets, which tell the one-byte fetch apart from the two-byte one;
- a start just below 0xFFFF, which separates wrapping inside the segment from carrying into the segment.

Running with no consumer shows the free-slot rule through the request count and the settled fill depth. A redirect while a long-latency fetch is in flight shows whether the stale word is dropped. Pops aimed at an empty queue show whether they corrupt the stream that follows.

// File: rtl/ibq_pkg.sv
// Shared widths and address arithmetic for the instruction prefetch queue.
package ibq_pkg;
    localparam int SEG_W  = 16;
    localparam int OFS_W  = 16;
    localparam int ADDR_W = 20;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    // Segment shifted by the address-width surplus plus the offset, truncated.
    function automatic logic [ADDR_W-1:0] seg_to_phys(input logic [SEG_W-1:0] seg,
                                                      input logic [OFS_W-1:0] ofs);
        return {seg, {(ADDR_W-SEG_W){1'b0}}} + {{(ADDR_W-OFS_W){1'b0}}, ofs};
    endfunction
endpackage

// File: rtl/ibq_addr_gen.sv
// Forms the word-aligned physical fetch address from segment and offset.
// Assumes the memory returns the whole aligned word that holds the offset.
module ibq_addr_gen
    import ibq_pkg::*;
(
    input  logic [SEG_W-1:0]  seg,
    input  logic [OFS_W-1:0]  ofs,
    output logic [ADDR_W-1:0] word_addr
);
    logic [ADDR_W-1:0] phys;

    // Physical address with the byte-select bit cleared.
    always_comb begin
        phys      = seg_to_phys(seg, ofs);
        word_addr = {phys[ADDR_W-1:1], 1'b0};
    end
endmodule

// File: rtl/ibq_fifo.sv
// Circular byte queue of DEPTH entries: up to two pushes (first, second in
// order) and one pop per cycle. Assumes the caller never pushes beyond the
// free space; a pop on an empty queue is ignored. clr wins over push and pop.
module ibq_fifo #(
    parameter int DEPTH = 6,
    parameter int LVL_W = $clog2(DEPTH + 1),
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [1:0]       push_n,
    input  logic [7:0]       b0,
    input  logic [7:0]       b1,
    input  logic             pop,
    output logic [7:0]       head,
    output logic [LVL_W-1:0] level,
    output logic             nonempty
);
    logic [7:0]       slot_q [DEPTH];
    logic [IDX_W-1:0] rd_q, wr_q, wr1;
    logic [LVL_W-1:0] level_q;
    logic             we0, we1, do_pop;

    function automatic logic [IDX_W-1:0] nxt(input logic [IDX_W-1:0] i);
        return (i == IDX_W'(DEPTH - 1)) ? '0 : i + 1'b1;
    endfunction

    // Write enables, second write slot and effective pop.
    always_comb begin
        we0    = (push_n != 2'd0);
        we1    = (push_n == 2'd2);
        wr1    = nxt(wr_q);
        do_pop = pop && (level_q != '0);
    end

    // Data slots: the first byte goes to wr_q, the second to the slot after it.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!clr && we0 && wr_q == IDX_W'(i))
                slot_q[i] <= b0;
            else if (!clr && we1 && wr1 == IDX_W'(i))
                slot_q[i] <= b1;
        end
    end

    // Pointers and fill level.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rd_q    <= '0;
            wr_q    <= '0;
            level_q <= '0;
        end else begin
            wr_q    <= we1 ? nxt(wr1) : (we0 ? wr1 : wr_q);
            rd_q    <= do_pop ? nxt(rd_q) : rd_q;
            level_q <= level_q + LVL_W'(push_n) - LVL_W'(do_pop);
        end
    end

    assign head     = slot_q[rd_q];
    assign level    = level_q;
    assign nonempty = (level_q != '0);
endmodule

// File: rtl/ibq_fetch_ctrl.sv
// Fetch sequencer: owns the fetch offset and a single outstanding word fetch.
// Issues only when the queue, counting the fetch in flight as two bytes, has
// two free slots. Turns a response into one or two byte pushes, and drops a
// response that belongs to a fetch overtaken by a flush.
module ibq_fetch_ctrl
    import ibq_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [OFS_W-1:0]  flush_ofs,
    input  logic [LVL_W-1:0]  level,
    input  logic              rsp_valid,
    input  logic [WORD_W-1:0] rsp_data,
    output logic              issue,
    output logic [OFS_W-1:0]  ofs,
    output logic [1:0]        push_n,
    output logic [7:0]        push_b0,
    output logic [7:0]        push_b1
);
    localparam logic [LVL_W:0] USED_MAX = (LVL_W+1)'(DEPTH - 2);

    logic [OFS_W-1:0] ofs_q;
    logic             inflight_q, odd_q, discard_q, accept;
    logic [LVL_W:0]   used;

    // Slot accounting and issue decision.
    always_comb begin
        used  = (LVL_W+1)'(level) + (inflight_q ? (LVL_W+1)'(2) : '0);
        issue = rst_n && !flush && !inflight_q && (used <= USED_MAX);
    end

    // Response to byte pushes: an odd fetch keeps only the upper byte.
    always_comb begin
        accept  = rsp_valid && inflight_q && !discard_q && !flush;
        push_n  = accept ? (odd_q ? 2'd1 : 2'd2) : 2'd0;
        push_b0 = odd_q ? rsp_data[15:8] : rsp_data[7:0];
        push_b1 = rsp_data[15:8];
    end

    // Offset, outstanding-fetch and discard state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_q      <= '0;
            inflight_q <= 1'b0;
            odd_q      <= 1'b0;
            discard_q  <= 1'b0;
        end else begin
            if (flush)
                ofs_q <= flush_ofs;
            else if (issue)
                ofs_q <= ofs_q + (ofs_q[0] ? OFS_W'(1) : OFS_W'(2));
            if (issue) begin
                inflight_q <= 1'b1;
                odd_q      <= ofs_q[0];
            end else if (rsp_valid) begin
                inflight_q <= 1'b0;
            end
            if (rsp_valid)
                discard_q <= 1'b0;
            else if (flush && inflight_q)
                discard_q <= 1'b1;
        end
    end

    assign ofs = ofs_q;
endmodule

// File: rtl/ibq_prefetcher.sv
// Instruction prefetch unit: fetch sequencer, address generator and byte
// queue. Assumes memory answers each request exactly once with mem_rvalid,
// at least one cycle after the request, and that flush is a single-cycle pulse.
module ibq_prefetcher
    import ibq_pkg::*;
#(
    parameter int DEPTH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEG_W-1:0]  code_seg,
    input  logic              flush,
    input  logic [OFS_W-1:0]  flush_ofs,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              q_valid,
    output logic [7:0]        q_byte,
    input  logic              q_pop
);
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic [LVL_W-1:0] fill_level;
    logic [OFS_W-1:0] fetch_ofs;
    logic [1:0]       push_n;
    logic [7:0]       push_b0, push_b1;

    ibq_fetch_ctrl #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .flush_ofs (flush_ofs),
        .level     (fill_level),
        .rsp_valid (mem_rvalid),
        .rsp_data  (mem_rdata),
        .issue     (mem_req),
        .ofs       (fetch_ofs),
        .push_n    (push_n),
        .push_b0   (push_b0),
        .push_b1   (push_b1)
    );

    ibq_addr_gen u_addr (
        .seg       (code_seg),
        .ofs       (fetch_ofs),
        .word_addr (mem_addr)
    );

    ibq_fifo #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (flush),
        .push_n   (push_n),
        .b0       (push_b0),
        .b1       (push_b1),
        .pop      (q_pop),
        .head     (q_byte),
        .level    (fill_level),
        .nonempty (q_valid)
    );
endmodule

// File: rtl/ibq_prefetcher_chk.sv
// Protocol and occupancy checks for the prefetcher, bound into the top.
module ibq_prefetcher_chk #(
    parameter int DEPTH = 6,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             mem_req,
    input logic [19:0]      mem_addr,
    input logic             mem_rvalid,
    input logic             q_valid,
    input logic [LVL_W-1:0] fill_level,
    input logic [15:0]      fetch_ofs
);
    // Quiet outputs during reset.
    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!mem_req && !q_valid); // R1
        end
    end

    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !mem_addr[0]); // R2
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req); // R3
    AST_ROOM_ON_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (fill_level <= LVL_W'(DEPTH - 2))); // R3
    AST_OFS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> fetch_ofs == $past(fetch_ofs) + ($past(fetch_ofs[0]) ? 16'd1 : 16'd2)); // R4
    AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_valid && !mem_rvalid) |=> !q_valid); // R7
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !q_valid); // R8
    AST_FLUSH_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !mem_req); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= LVL_W'(DEPTH)); // R11
endmodule

bind ibq_prefetcher ibq_prefetcher_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .q_valid    (q_valid),
    .fill_level (fill_level),
    .fetch_ofs  (fetch_ofs)
);

// File: tb/ibq_prefetcher_bench.sv
`timescale 1ns/1ps
module ibq_prefetcher_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] code_seg = '0;
    logic        flush = 1'b0;
    logic [15:0] flush_ofs = '0;
    logic        mem_req;
    logic [19:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        q_valid;
    logic [7:0]  q_byte;
    logic        q_pop = 1'b0;

    int errors = 0, checks = 0, cycles = 0;
    int lat = 1, pop_pct = 100, popped = 0;
    int req_cnt = 0, pending = 0, cnt = 0;
    logic [19:0] paddr, first_addr;
    logic [7:0]  exp_q[$];
    string       tag = "R6";

    always #4 clk = ~clk;

    ibq_prefetcher u_ibq_prefetcher (
        .clk(clk), .rst_n(rst_n), .code_seg(code_seg), .flush(flush),
        .flush_ofs(flush_ofs), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .q_valid(q_valid),
        .q_byte(q_byte), .q_pop(q_pop)
    );

    function automatic logic [7:0] bf(input logic [19:0] p);
        return p[7:0] ^ {p[19:16], p[11:8]} ^ 8'h5A;
    endfunction

    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
        return {s, 4'b0} + {4'b0, o};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Memory model: accepts a request, answers after lat cycles.
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (!rst_n) begin
            pending = 0;
            req_cnt = 0;
        end else begin
            if (pending != 0) begin
                if (cnt == 0) begin
                    mem_rvalid <= 1'b1;
                    mem_rdata  <= {bf(paddr | 20'h1), bf(paddr)};
                    pending = 0;
                end else cnt--;
            end
            if (flush) req_cnt = 0;
            if (mem_req) begin
                if (req_cnt == 0) first_addr = mem_addr;
                req_cnt++;
                pending = 1;
                paddr = mem_addr;
                cnt = lat - 1;
            end
        end
    end

    // Monitor: every byte popped is compared against the scoreboard.
    always @(posedge clk) begin
        if (rst_n && q_valid && q_pop && !flush) begin
            if (exp_q.size() == 0) check(1'b0, tag, "unexpected byte", q_byte, 0);
            else check(q_byte == exp_q[0], tag, "byte", q_byte, exp_q[0]);
            if (exp_q.size() != 0) void'(exp_q.pop_front());
            popped++;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Driver: redirect and load the scoreboard with the expected stream.
    task automatic redirect(input logic [15:0] s, input logic [15:0] o, input string t);
        @(negedge clk);
        q_pop = 1'b0;
        code_seg = s;
        flush = 1'b1;
        flush_ofs = o;
        exp_q.delete();
        for (int k = 0; k < 96; k++) exp_q.push_back(bf(phys(s, o + 16'(k))));
        tag = t;
        @(negedge clk);
        flush = 1'b0;
        check(q_valid == 1'b0, "R8", "q_valid after flush", q_valid, 0);
        while (req_cnt == 0) @(negedge clk);
        check(first_addr == {phys(s, o)[19:1], 1'b0}, "R2", "first fetch address",
              first_addr, {phys(s, o)[19:1], 1'b0});
    endtask

    task automatic consume(input int n);
        popped = 0;
        forever begin
            @(negedge clk);
            if (popped >= n) begin
                q_pop = 1'b0;
                break;
            end
            q_pop = ($urandom_range(0, 99) < pop_pct);
        end
    endtask

    task automatic pop_burst(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            q_pop = 1'b1;
        end
        @(negedge clk);
        q_pop = 1'b0;
    endtask

    initial begin
        repeat (3) begin
            @(negedge clk);
            check(!q_valid && !mem_req, "R1", "outputs in reset", {q_valid, mem_req}, 0);
        end
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(first_addr == 20'h0, "R1", "first address after reset", first_addr, 0);

        // Even start, full-rate consumer.
        lat = 1; pop_pct = 100;
        redirect(16'h1005, 16'h0100, "R4");
        consume(40);
        // Random pops, longer latency.
        lat = 3; pop_pct = 50;
        redirect(16'h2468, 16'h0A00, "R6");
        consume(40);
        // Odd start.
        lat = 2; pop_pct = 70;
        redirect(16'h1005, 16'h5555, "R5");
        consume(30);
        // Wrap inside the segment.
        lat = 2; pop_pct = 100;
        redirect(16'hF000, 16'hFFFC, "R10");
        consume(12);
        // Mid-stream redirect.
        lat = 2; pop_pct = 50;
        redirect(16'h0300, 16'h0200, "R8");
        consume(10);
        redirect(16'h0300, 16'h0600, "R8");
        consume(10);

        // Fill without consumer: even start.
        lat = 2;
        redirect(16'h0400, 16'h2000, "R11");
        repeat (40) @(negedge clk);
        check(req_cnt == 3, "R3", "requests for even fill", req_cnt, 3);
        lat = 30;
        pop_burst(6);
        check(q_valid == 1'b0, "R11", "empty after 6 pops", q_valid, 0);
        repeat (40) @(negedge clk);
        // Fill without consumer: odd start.
        lat = 2;
        redirect(16'h0400, 16'h2001, "R11");
        repeat (40) @(negedge clk);
        check(req_cnt == 3, "R3", "requests for odd fill", req_cnt, 3);
        lat = 30;
        pop_burst(5);
        check(q_valid == 1'b0, "R11", "empty after 5 pops", q_valid, 0);
        repeat (40) @(negedge clk);

        // Pops on an empty queue.
        lat = 20;
        redirect(16'h0500, 16'h3000, "R7");
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            q_pop = 1'b1;
            check(q_valid == 1'b0, "R7", "q_valid while empty", q_valid, 0);
        end
        @(negedge clk);
        q_pop = 1'b0;
        lat = 1; pop_pct = 100;
        consume(8);

        // Redirect with a fetch in flight.
        lat = 12;
        redirect(16'h0600, 16'h4000, "R9");
        lat = 1;
        repeat (3) @(negedge clk);
        redirect(16'h0600, 16'h8000, "R9");
        pop_pct = 100;
        consume(20);

        repeat (5) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule